// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block takes a fixed-point word in one format and expresses it in another. Each format is fixed at build time by three numbers: total width, the number of fractional bits, and whether the code is signed (two's complement) or unsigned. The input and output formats may differ in all three. The binary points are aligned first. The fractional part is then either rounded or truncated to the output precision. Finally the result is fitted into the output range by saturating, by wrapping, or by keeping the wrapped value and raising an overflow flag.

Two run-time selects choose the quantization mode and the overflow mode for each word, so one instance can serve several numeric policies. The conversion is combinational and is followed by a single register stage. An input word qualified by `valid_i` produces a registered output word and flag one clock later.

Top module: `fxc_convert`

## Requirements
- R1: A signed code of W bits with F fractional bits has the value code·2^-F, with the code read as two's complement. An unsigned code reads as a plain binary integer times 2^-F.
- R2: When the output has more integer bits than the input, the input is sign-extended (signed input) or zero-padded (unsigned input). When the output has more fractional bits, the new low bits are zero.
- R3: With `rnd_mode_i` = 0 (truncate), the fractional bits that are dropped are discarded. For signed values this rounds toward minus infinity.
- R4: With `rnd_mode_i` = 1 (round), the result is the nearest output code. An exact tie moves away from zero: upward for non-negative values and downward for negative values.
- R5: Rounding happens before the range check. A round-up that moves past the largest output code is an overflow.
- R6: With `ovf_mode_i` = 2'b00 (saturate), an out-of-range result becomes the largest or smallest output code, and `ovf_o` stays 0. A negative value converted to an unsigned output is out of range and gives 0.
- R7: With `ovf_mode_i` = 2'b01 (wrap), the output keeps the low OUT_W bits of the exact result, and `ovf_o` stays 0.
- R8: With `ovf_mode_i` = 2'b10 or 2'b11 (error), the output is the wrapped value, and `ovf_o` is 1 exactly when the result is out of range.
- R9: `valid_o` equals `valid_i` delayed by one clock. `ovf_o` is only high together with `valid_o`. `data_o` holds its value while `valid_i` is low.
- R10: While `rst_ni` is low, `data_o`, `valid_o` and `ovf_o` are 0.
- R11: When the output has at least the input's integer and fractional bits (and is signed if the input is signed), the conversion is exact and `ovf_o` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| data_i | input | IN_W | Input code |
| rnd_mode_i | input | 1 | 0 truncate, 1 round half away from zero |
| ovf_mode_i | input | 2 | 00 saturate, 01 wrap, 1x error flag |
| valid_o | output | 1 | Output word qualifier |
| data_o | output | OUT_W | Output code |
| ovf_o | output | 1 | Out-of-range flag (error mode only) |

## Verification
The bench uses three instances: the default narrowing signed converter, a widening lossless one, and a narrowing one with unsigned output. All three see the same stimulus. A wrong alignment shift, a wrong tie direction or a wrong clamp bound shows up as a wrong `data_o` in the cycle right after the word is accepted. A wrong overflow decision shows up there as a wrong `ovf_o`. Directed words sit on ties of both signs, on the round-up that crosses the maximum, and on negative-to-unsigned conversion. A wrong hold or valid path shows up on the idle cycle that follows each word.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  typedef enum logic [1:0] {
    OVF_SAT  = 2'b00,
    OVF_WRAP = 2'b01,
    OVF_ERR  = 2'b10,
    OVF_ERRX = 2'b11
  } ovf_mode_e;

  typedef enum logic {
    Q_TRUNC = 1'b0,
    Q_ROUND = 1'b1
  } q_mode_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fxc_align.sv
module fxc_align #(
  parameter int IN_W      = 11,
  parameter bit IN_SIGNED = 1'b1,
  parameter int SH_UP     = 0,
  parameter int WW        = IN_W + 2 + SH_UP
) (
  input  logic [IN_W-1:0]        din_i,
  output logic signed [WW-1:0]   dout_o
);
  logic                 ext_bit;
  logic signed [WW-1:0] ext;

  generate
    if (IN_SIGNED) begin : g_sext
      assign ext_bit = din_i[IN_W-1];
    end else begin : g_zext
      assign ext_bit = 1'b0;
    end
  endgenerate

  assign ext    = {{(WW-IN_W){ext_bit}}, din_i};
  // new low fraction bits are zero
  assign dout_o = ext <<< SH_UP;
endmodule

// File: rtl/fxc_quant.sv
module fxc_quant #(
  parameter int WW    = 13,
  parameter int SH_DN = 0
) (
  input  logic signed [WW-1:0] x_i,
  input  fxc_pkg::q_mode_e     mode_i,
  output logic signed [WW-1:0] q_o
);
  import fxc_pkg::*;

  generate
    if (SH_DN == 0) begin : g_pass
      assign q_o = x_i;
    end else begin : g_drop
      localparam logic [WW-1:0] HALF = WW'(1) << (SH_DN-1);
      logic signed [WW-1:0] bias;
      logic signed [WW-1:0] sum;
      always_comb begin
        // negative ties need half-1 so that floor moves away from zero
        if (mode_i != Q_ROUND)  bias = '0;
        else if (x_i[WW-1])     bias = $signed(HALF - WW'(1));
        else                    bias = $signed(HALF);
        sum = x_i + bias;
        q_o = sum >>> SH_DN;
      end
    end
  endgenerate
endmodule

// File: rtl/fxc_range.sv
module fxc_range #(
  parameter int WW         = 13,
  parameter int OUT_W      = 5,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic signed [WW-1:0] q_i,
  input  fxc_pkg::ovf_mode_e   mode_i,
  output logic [OUT_W-1:0]     data_o,
  output logic                 ovf_o
);
  import fxc_pkg::*;

  localparam int CW = imax(WW, OUT_W + 2);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] HI_U  = OUT_SIGNED ? ((ONE << (OUT_W-1)) - ONE) : ((ONE << OUT_W) - ONE);
  localparam logic [CW-1:0] LO_U  = OUT_SIGNED ? (~(ONE << (OUT_W-1)) + ONE) : '0;
  localparam logic signed [CW-1:0] HI = $signed(HI_U);
  localparam logic signed [CW-1:0] LO = $signed(LO_U);

  logic signed [CW-1:0] qx;
  logic                 above, below, oor;

  always_comb begin
    qx    = q_i;
    above = qx > HI;
    below = qx < LO;
    oor   = above | below;
    unique case (mode_i)
      OVF_SAT: begin
        if (above)      data_o = HI_U[OUT_W-1:0];
        else if (below) data_o = LO_U[OUT_W-1:0];
        else            data_o = qx[OUT_W-1:0];
      end
      default:          data_o = qx[OUT_W-1:0];
    endcase
    ovf_o = oor & mode_i[1];
  end
endmodule

// File: rtl/fxc_convert.sv
module fxc_convert #(
  parameter int IN_W       = 11,
  parameter int IN_FRAC    = 9,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 5,
  parameter int OUT_FRAC   = 4,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic             rnd_mode_i,
  input  logic [1:0]       ovf_mode_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             ovf_o
);
  import fxc_pkg::*;

  localparam int SH_UP = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;
  localparam int SH_DN = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
  localparam int WW    = IN_W + 2 + SH_UP;

  logic signed [WW-1:0] aligned, quant;
  logic [OUT_W-1:0]     conv;
  logic                 conv_ovf;

  fxc_align #(.IN_W(IN_W), .IN_SIGNED(IN_SIGNED), .SH_UP(SH_UP), .WW(WW)) u_align (
    .din_i  (data_i),
    .dout_o (aligned)
  );

  fxc_quant #(.WW(WW), .SH_DN(SH_DN)) u_quant (
    .x_i    (aligned),
    .mode_i (q_mode_e'(rnd_mode_i)),
    .q_o    (quant)
  );

  fxc_range #(.WW(WW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED)) u_range (
    .q_i    (quant),
    .mode_i (ovf_mode_e'(ovf_mode_i)),
    .data_o (conv),
    .ovf_o  (conv_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i & conv_ovf;
      if (valid_i) data_o <= conv;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R9
  ovf_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o);
  // R7
  quiet_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ovf_mode_i[1]) |=> !ovf_o);
endmodule

// File: tb/tb_fxc_convert.sv
module tb_fxc_convert;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [10:0] din = '0;
  logic        rnd = 1'b0;
  logic [1:0]  mode = 2'b00;

  logic       v_a, o_a, v_f, o_f, v_u, o_u;
  logic [4:0]  d_a;
  logic [12:0] d_f;
  logic [3:0]  d_u;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fxc_convert dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .data_i(din),
    .rnd_mode_i(rnd), .ovf_mode_i(mode), .valid_o(v_a), .data_o(d_a), .ovf_o(o_a));

  fxc_convert #(.OUT_W(13), .OUT_FRAC(10)) dut_fp (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .data_i(din),
    .rnd_mode_i(rnd), .ovf_mode_i(mode), .valid_o(v_f), .data_o(d_f), .ovf_o(o_f));

  fxc_convert #(.OUT_W(4), .OUT_FRAC(2), .OUT_SIGNED(1'b0)) dut_u (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .data_i(din),
    .rnd_mode_i(rnd), .ovf_mode_i(mode), .valid_o(v_u), .data_o(d_u), .ovf_o(o_u));

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // d>0 drops d fraction bits, d<0 adds -d
  function automatic int model(input int x, input int d, input int ow, input bit os,
                               input bit rn, input int md, output bit ovf, output bit oor);
    int r, m, hi, lo;
    if (d > 0) begin
      if (rn) begin
        m = (x < 0) ? -x : x;
        m = (m + (1 << (d-1))) >> d;
        r = (x < 0) ? -m : m;
      end else r = x >>> d;
    end else r = x <<< (-d);
    hi = os ? (1 << (ow-1)) - 1 : (1 << ow) - 1;
    lo = os ? -(1 << (ow-1)) : 0;
    oor = (r > hi) || (r < lo);
    ovf = 1'b0;
    if (oor) begin
      if (md == 0) r = (r > hi) ? hi : lo;
      else if (md >= 2) ovf = 1'b1;
    end
    return r & ((1 << ow) - 1);
  endfunction

  function automatic string tag_of(input bit oor, input bit rn, input int md);
    if (oor) return (md == 0) ? "R6" : (md == 1) ? "R7" : "R8";
    return rn ? "R4" : "R3";
  endfunction

  int last_a, last_f, last_u;

  task automatic run(input int x, input bit rn, input int md, input string tag);
    int ea, ef, eu;
    bit va, vf, vu, oa, of_, ou;
    @(negedge clk);
    valid = 1'b1; din = x[10:0]; rnd = rn; mode = md[1:0];
    ea = model(x, 5, 5, 1'b1, rn, md, va, oa);
    ef = model(x, -1, 13, 1'b1, rn, md, vf, of_);
    eu = model(x, 7, 4, 1'b0, rn, md, vu, ou);
    @(negedge clk);
    valid = 1'b0;
    chk(int'(v_a), 1, "R9 valid");
    chk(int'(d_a), ea, (tag != "") ? tag : tag_of(oa, rn, md));
    chk(int'(o_a), int'(va), "R8 ovf");
    chk(int'(d_f), ef, "R2 R11 data");
    chk(int'(o_f), 0, "R11 ovf");
    chk(int'(d_u), eu, (x < 0 && md == 0) ? "R6 unsigned" : "R1 unsigned");
    chk(int'(o_u), int'(vu), "R8 unsigned ovf");
    last_a = ea; last_f = ef; last_u = eu;
  endtask

  task automatic idle();
    @(negedge clk);
    chk(int'(v_a), 0, "R9 valid low");
    chk(int'(o_a), 0, "R9 ovf low");
    chk(int'(d_a), last_a, "R9 hold");
    chk(int'(d_u), last_u, "R9 hold unsigned");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(int'(v_a), 0, "R10 valid");
    chk(int'(d_a), 0, "R10 data");
    chk(int'(o_a), 0, "R10 ovf");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(int'(v_a), 0, "R10 after release");

    run(-1024, 1'b0, 0, "R1 min sat");
    run(1023, 1'b0, 0, "R1 max sat");
    run(16, 1'b1, 1, "R4 pos tie");
    run(-16, 1'b1, 1, "R4 neg tie");
    run(15, 1'b1, 1, "R4 below tie");
    run(-15, 1'b1, 1, "R4 neg below tie");
    run(-16, 1'b0, 1, "R3 floor");
    run(16, 1'b0, 1, "R3 drop");
    run(496, 1'b1, 0, "R5 round sat");
    run(496, 1'b1, 2, "R5 round err");
    run(496, 1'b0, 2, "R5 trunc err");
    idle();
    run(-64, 1'b0, 0, "");
    run(-1, 1'b1, 0, "");
    run(600, 1'b0, 1, "R7 wrap");
    run(-700, 1'b1, 3, "R8 err");
    idle();

    for (int i = 0; i < 400; i++) begin
      int v;
      v = int'($urandom_range(0, 2047));
      if (v >= 1024) v = v - 2048;
      run(v, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), "");
      if ($urandom_range(0, 3) == 0) idle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule